// File: doc/BRIEF.md
# 32-pin GPIO register block

This block is a memory-mapped controller for a bank of general-purpose pins, reached through a simple word-wide register read/write bus. Per pin it holds five pieces of state: an output data bit, a direction bit, a pull-disable bit and two alternate-function select bits. From these it drives each pad's output enable, output value, pull enable, pull direction and a two-bit function select. It also samples the pad input levels through a synchroniser, so software can read them back.

Both the data register and the direction register have write-1-to-set and write-1-to-clear alias addresses. Software can change single pins with one write and no read-modify-write. While a pin is an input with its pull enabled, its output data bit also picks the pull direction. Changing that bit therefore also changes the level the pin drives once it becomes an output.

The bus data width equals the pin count. A write is accepted on the rising edge at which `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high. The asynchronous active-low reset is released through a two-flop reset synchroniser inside the block.

Top module: `gpio_regblock`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every pin is an input (`pin_oe` = 0), `pin_out` = 0, `pull_en` = all ones, `pull_up` = 0, `func_sel` = 0, and every register reads back 0.
- R2: A write to offset 0x00 loads the output data register. A write to 0x04 ORs the word into it. A write to 0x08 clears each bit that is 1 in the word. No other bit changes.
- R3: A write to 0x10 loads the direction register. A write to 0x14 sets the bits that are 1 in the word, and a write to 0x18 clears them. `pin_oe[n]` equals direction bit n, where 1 means output.
- R4: The pull-disable register is written and read at 0x0C. `pull_en[n]` is 1 only when pull-disable bit n is 0 and pin n is an input.
- R5: `pin_out[n]` and `pull_up[n]` both equal output data bit n, whatever the direction. While the pull is enabled, 1 selects pull-up and 0 selects pull-down.
- R6: Select A is written at 0x20 and select B at 0x24. `func_sel[2n+1:2n]` = {B[n], A[n]}, where 00 means plain GPIO, 01 function A, 10 function B and 11 function C.
- R7: A read of 0x00 returns the pin input levels after a two-flop synchroniser. A level applied before rising edge k is not visible after edge k and is visible after edge k+1. Bit n belongs to pin n.
- R8: Reads of 0x04 and 0x08 return the output data register. Reads of 0x14 and 0x18 return the direction register. Reads of 0x0C, 0x10, 0x20 and 0x24 return their own registers. `bus_rdata` is 0 whenever `bus_rd` is low.
- R9: A write to any other offset (for example 0x1C, 0x28, 0x40, 0xFC, 0x01) changes no register and no output. A read from such an offset returns 0.
- R10: A write takes effect on the rising edge on which it is accepted, so a read and the pad outputs show the new value before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted on the rising edge |
| bus_rd | input | 1 | Read strobe, enables read data |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |
| pull_en | output | 32 | Per-pin pull resistor enable |
| pull_up | output | 32 | Per-pin pull direction, 1 = up |
| func_sel | output | 64 | Two bits per pin, function select |

## Verification
A wrong bit in any state register appears on a pad output before the next clock edge. The data bit drives both `pin_out` and `pull_up`, the direction bit drives `pin_oe` and gates `pull_en`, and the select bits drive `func_sel`. The register's own read address shows the same bit with no delay. The only delayed path is the input synchroniser: a missing or extra stage shows as data read back one edge early or one edge late after a pin change. The bench compares every output and every readable offset against a model after each write, so a corrupted bit is reported at the first check after the write that caused it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_DSET  = 8'h04;
  localparam logic [7:0] OFS_DCLR  = 8'h08;
  localparam logic [7:0] OFS_PDIS  = 8'h0C;
  localparam logic [7:0] OFS_DIR   = 8'h10;
  localparam logic [7:0] OFS_DIRS  = 8'h14;
  localparam logic [7:0] OFS_DIRC  = 8'h18;
  localparam logic [7:0] OFS_ALTA  = 8'h20;
  localparam logic [7:0] OFS_ALTB  = 8'h24;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DSET, SEL_DCLR, SEL_PDIS,
    SEL_DIR, SEL_DIRS, SEL_DIRC, SEL_ALTA, SEL_ALTB
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    sel = SEL_NONE;
    if      (addr == AW'(OFS_DATA)) sel = SEL_DATA;
    else if (addr == AW'(OFS_DSET)) sel = SEL_DSET;
    else if (addr == AW'(OFS_DCLR)) sel = SEL_DCLR;
    else if (addr == AW'(OFS_PDIS)) sel = SEL_PDIS;
    else if (addr == AW'(OFS_DIR))  sel = SEL_DIR;
    else if (addr == AW'(OFS_DIRS)) sel = SEL_DIRS;
    else if (addr == AW'(OFS_DIRC)) sel = SEL_DIRC;
    else if (addr == AW'(OFS_ALTA)) sel = SEL_ALTA;
    else if (addr == AW'(OFS_ALTB)) sel = SEL_ALTB;
  end
endmodule

// File: rtl/gpio_bitreg.sv
// Register with load, bitwise set and bitwise clear strobes.
module gpio_bitreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = ld | set | clr;
    q_nxt = q;
    if (ld)  q_nxt = wdata;
    if (set) q_nxt = q | wdata;
    if (clr) q_nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_nxt;

  always_comb begin
    stg_nxt[0] = din;
    for (int s = 1; s < STAGES; s++) stg_nxt[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map #(
  parameter int N = 32
) (
  input  logic [N-1:0]   dat,
  input  logic [N-1:0]   dir,
  input  logic [N-1:0]   pdis,
  input  logic [N-1:0]   alta,
  input  logic [N-1:0]   altb,
  output logic [N-1:0]   pin_oe,
  output logic [N-1:0]   pin_out,
  output logic [N-1:0]   pull_en,
  output logic [N-1:0]   pull_up,
  output logic [2*N-1:0] func_sel
);
  for (genvar n = 0; n < N; n++) begin : g_pin
    assign pin_oe[n]        = dir[n];
    assign pin_out[n]       = dat[n];
    assign pull_en[n]       = ~pdis[n] & ~dir[n];
    assign pull_up[n]       = dat[n];
    assign func_sel[2*n+:2] = {altb[n], alta[n]};
  end
endmodule

// File: rtl/gpio_regblock.sv
module gpio_regblock
  import gpio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pull_en,
  output logic [NPINS-1:0]   pull_up,
  output logic [2*NPINS-1:0] func_sel
);
  localparam int DW = NPINS;

  // Reset: asserted asynchronously, released synchronously
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  reg_sel_e sel;
  gpio_addr_dec #(.AW(AW)) u_dec (.addr(bus_addr), .sel(sel));

  logic [DW-1:0] dat_q, dir_q, pdis_q, alta_q, altb_q, sync_q;

  gpio_bitreg #(.W(DW)) u_dat (
    .clk(clk), .rst_n(rst_q_n),
    .ld (bus_wr && sel == SEL_DATA),
    .set(bus_wr && sel == SEL_DSET),
    .clr(bus_wr && sel == SEL_DCLR),
    .wdata(bus_wdata), .q(dat_q));

  gpio_bitreg #(.W(DW)) u_dir (
    .clk(clk), .rst_n(rst_q_n),
    .ld (bus_wr && sel == SEL_DIR),
    .set(bus_wr && sel == SEL_DIRS),
    .clr(bus_wr && sel == SEL_DIRC),
    .wdata(bus_wdata), .q(dir_q));

  gpio_bitreg #(.W(DW)) u_pdis (
    .clk(clk), .rst_n(rst_q_n),
    .ld(bus_wr && sel == SEL_PDIS), .set(1'b0), .clr(1'b0),
    .wdata(bus_wdata), .q(pdis_q));

  gpio_bitreg #(.W(DW)) u_alta (
    .clk(clk), .rst_n(rst_q_n),
    .ld(bus_wr && sel == SEL_ALTA), .set(1'b0), .clr(1'b0),
    .wdata(bus_wdata), .q(alta_q));

  gpio_bitreg #(.W(DW)) u_altb (
    .clk(clk), .rst_n(rst_q_n),
    .ld(bus_wr && sel == SEL_ALTB), .set(1'b0), .clr(1'b0),
    .wdata(bus_wdata), .q(altb_q));

  gpio_in_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .din(pin_in), .dout(sync_q));

  gpio_pad_map #(.N(NPINS)) u_pads (
    .dat(dat_q), .dir(dir_q), .pdis(pdis_q), .alta(alta_q), .altb(altb_q),
    .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
    .pull_up(pull_up), .func_sel(func_sel));

  // Read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_DATA:           rd_mux = sync_q;
      SEL_DSET, SEL_DCLR: rd_mux = dat_q;
      SEL_PDIS:           rd_mux = pdis_q;
      SEL_DIR, SEL_DIRS,
      SEL_DIRC:           rd_mux = dir_q;
      SEL_ALTA:           rd_mux = alta_q;
      SEL_ALTB:           rd_mux = altb_q;
      default:            rd_mux = '0;
    endcase
  end
  assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/gpio_regblock_chk.sv
module gpio_regblock_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_q_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [AW-1:0]      bus_addr,
  input logic [NPINS-1:0]   bus_wdata,
  input logic [NPINS-1:0]   bus_rdata,
  input logic [NPINS-1:0]   pin_oe,
  input logic [NPINS-1:0]   pin_out,
  input logic [NPINS-1:0]   pull_en,
  input logic [NPINS-1:0]   pull_up,
  input logic [2*NPINS-1:0] func_sel
);
  logic mapped;
  assign mapped = (bus_addr == AW'(8'h00)) || (bus_addr == AW'(8'h04)) ||
                  (bus_addr == AW'(8'h08)) || (bus_addr == AW'(8'h0C)) ||
                  (bus_addr == AW'(8'h10)) || (bus_addr == AW'(8'h14)) ||
                  (bus_addr == AW'(8'h18)) || (bus_addr == AW'(8'h20)) ||
                  (bus_addr == AW'(8'h24));

  // R1: held in reset, pads idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && pin_out == '0 && func_sel == '0));

  // R2: data-set ORs in the written word
  p_dset_or_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == AW'(8'h04)) |=>
      pin_out == ($past(pin_out) | $past(bus_wdata)));

  // R2: data-clear removes the written ones
  p_dclr_and_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == AW'(8'h08)) |=>
      pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  // R3: direction-set and direction-clear
  p_dirs_or_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == AW'(8'h14)) |=>
      pin_oe == ($past(pin_oe) | $past(bus_wdata)));
  p_dirc_and_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && bus_addr == AW'(8'h18)) |=>
      pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

  // R4: no pull on a driven pin
  p_pull_off_out_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pull_en & pin_oe) == '0);

  // R5: pull direction follows the output data bit
  p_pull_dir_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    pull_up == pin_out);

  // R9: unmapped write leaves every output unchanged
  p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && !mapped) |=>
      ($stable(pin_oe) && $stable(pin_out) && $stable(pull_en) && $stable(func_sel)));

  // R9 / R8: unmapped reads and idle bus return zero
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bus_rd || !mapped) |-> bus_rdata == '0);
endmodule

bind gpio_regblock gpio_regblock_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
  .pull_up(pull_up), .func_sel(func_sel));

// File: tb/gpio_regblock_bench.sv
`timescale 1ns/1ps
module gpio_regblock_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in;
  logic [31:0] pin_oe, pin_out, pull_en, pull_up;
  logic [63:0] func_sel;

  always #2 clk = ~clk;

  gpio_regblock u_gpio_regblock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .func_sel(func_sel));

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] m_dat, m_dir, m_pd, m_a, m_b, m_pin;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_rd = 1'b0;
    #0.5;
  endtask

  task automatic check_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, {32'h0, d}, {32'h0, exp});
  endtask

  function automatic logic [63:0] exp_func(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] f;
    for (int n = 0; n < 32; n++) f[2*n+:2] = {b[n], a[n]};
    return f;
  endfunction

  task automatic check_all(input string tag);
    chk({"R3 pin_oe ", tag},   {32'h0, pin_oe},  {32'h0, m_dir});
    chk({"R5 pin_out ", tag},  {32'h0, pin_out}, {32'h0, m_dat});
    chk({"R4 pull_en ", tag},  {32'h0, pull_en}, {32'h0, ~m_pd & ~m_dir});
    chk({"R5 pull_up ", tag},  {32'h0, pull_up}, {32'h0, m_dat});
    chk({"R6 func_sel ", tag}, func_sel, exp_func(m_a, m_b));
    check_rd({"R7 rd data ", tag}, 8'h00, m_pin);
    check_rd({"R8 rd dset ", tag}, 8'h04, m_dat);
    check_rd({"R8 rd dclr ", tag}, 8'h08, m_dat);
    check_rd({"R4 rd pdis ", tag}, 8'h0C, m_pd);
    check_rd({"R8 rd dir ", tag},  8'h10, m_dir);
    check_rd({"R8 rd dirs ", tag}, 8'h14, m_dir);
    check_rd({"R8 rd dirc ", tag}, 8'h18, m_dir);
    check_rd({"R6 rd alta ", tag}, 8'h20, m_a);
    check_rd({"R6 rd altb ", tag}, 8'h24, m_b);
    check_rd({"R9 rd hole ", tag}, 8'h1C, 32'h0);
  endtask

  function automatic logic [31:0] pat(input int k);
    logic [31:0] x;
    x = 32'(k) * 32'h9E37_79B9;
    return x ^ (x >> 13) ^ (32'(k) << 3);
  endfunction

  initial begin
    logic [7:0] holes [5];
    logic [31:0] d;
    holes = '{8'h1C, 8'h28, 8'h40, 8'hFC, 8'h01};
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 32'h0;
    m_dat = '0; m_dir = '0; m_pd = '0; m_a = '0; m_b = '0; m_pin = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    chk("R1 pin_oe",   {32'h0, pin_oe},  64'h0);
    chk("R1 pin_out",  {32'h0, pin_out}, 64'h0);
    chk("R1 pull_en",  {32'h0, pull_en}, {32'h0, 32'hFFFF_FFFF});
    chk("R1 pull_up",  {32'h0, pull_up}, 64'h0);
    chk("R1 func_sel", func_sel, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after reset");

    // R10: write visible before the next edge
    wr(8'h00, 32'hA5A5_0F0F); m_dat = 32'hA5A5_0F0F;
    check_rd("R10 data load visible", 8'h04, 32'hA5A5_0F0F);
    chk("R10 pin_out", {32'h0, pin_out}, {32'h0, 32'hA5A5_0F0F});
    wr(8'h00, 32'h0); m_dat = '0;

    // R2 / R3: walking-one set and clear on every pin
    for (int i = 0; i < 32; i++) begin
      wr(8'h04, 32'h1 << i); m_dat |= 32'h1 << i;
      chk("R2 walk set", {32'h0, pin_out}, {32'h0, m_dat});
      wr(8'h14, 32'h1 << i); m_dir |= 32'h1 << i;
      chk("R3 walk dir set", {32'h0, pin_oe}, {32'h0, m_dir});
    end
    for (int i = 0; i < 32; i += 2) begin
      wr(8'h08, 32'h1 << i); m_dat &= ~(32'h1 << i);
      chk("R2 walk clr", {32'h0, pin_out}, {32'h0, m_dat});
      wr(8'h18, 32'h3 << i); m_dir &= ~(32'h3 << i);
      chk("R3 walk dir clr", {32'h0, pin_oe}, {32'h0, m_dir});
    end
    check_all("R2 R3 walk end");

    // Mixed operation sweep over all offsets, including holes (R9)
    for (int k = 1; k <= 100; k++) begin
      d = pat(k);
      case (k % 10)
        0: begin wr(8'h00, d); m_dat = d; end
        1: begin wr(8'h04, d); m_dat |= d; end
        2: begin wr(8'h08, d); m_dat &= ~d; end
        3: begin wr(8'h0C, d); m_pd = d; end
        4: begin wr(8'h10, d); m_dir = d; end
        5: begin wr(8'h14, d); m_dir |= d; end
        6: begin wr(8'h18, d); m_dir &= ~d; end
        7: begin wr(8'h20, d); m_a = d; end
        8: begin wr(8'h24, d); m_b = d; end
        default: begin
          wr(holes[(k / 10) % 5], d);
          check_rd("R9 hole read", holes[(k / 10) % 5], 32'h0);
        end
      endcase
      check_all("sweep");
    end

    // R8: idle read strobe gives zero
    bus_addr = 8'h10; #0.5;
    chk("R8 rd low", {32'h0, bus_rdata}, 64'h0);

    // R7: synchroniser latency with walking and patterned inputs
    for (int i = 0; i < 36; i++) begin
      logic [31:0] v;
      v = (i < 32) ? (32'h1 << i) : pat(i + 200);
      @(negedge clk); pin_in = v;
      check_rd("R7 before edge", 8'h00, m_pin);
      @(negedge clk);
      check_rd("R7 after one edge", 8'h00, m_pin);
      @(negedge clk);
      check_rd("R7 after two edges", 8'h00, v);
      m_pin = v;
    end

    // R4 / R5: pull direction with pins as inputs
    wr(8'h10, 32'h0); m_dir = '0;
    wr(8'h0C, 32'h0000_FFFF); m_pd = 32'h0000_FFFF;
    wr(8'h00, 32'h00FF_00FF); m_dat = 32'h00FF_00FF;
    check_all("R4 R5 pull mix");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule